// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers a configurable number of interrupt request lines (one to thirty-two) into one interrupt output for a processor. Each request is captured in a status register. A per-input compile-time mask decides whether the input is captured on a rising edge or while its line is high. Status bits are combined with an enable register to give the pending set. A registered output raises the processor interrupt while anything is pending and both master-enable bits are set.

Software reaches the block through a simple word-addressed register port. It can load the enable register whole, or set and clear single enable bits without a read-modify-write. It acknowledges requests by writing ones. It finds the request to serve by reading a vector register, which returns the lowest-numbered pending input, or all-ones when none is pending.

Top module: `irq_hub`

## Requirements
- R1: Registers are selected by byte address bits [4:2]: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master enable. Writes to status, pending and vector have no effect. Acknowledge, set-enable and clear-enable read as zero.
- R2: An input whose kind-mask bit is 1 sets its status bit on the clock edge that first sees the line high after it was low. A line that stays high does not set the bit again after an acknowledge.
- R3: An input whose kind-mask bit is 0 sets its status bit at every clock edge where its line is high. An acknowledge on the same edge does not clear the bit, so it is cleared only once the line has dropped.
- R4: Writing the acknowledge register clears each status bit written as one and leaves the others. Writing all-ones clears every status bit that is not being set again on the same edge.
- R5: Writing the enable register loads it, so writing zero disables all inputs. Set-enable ORs the written ones into it. Clear-enable clears the bits written as one. Zero bits leave enables unchanged.
- R6: The pending register reads as status AND enable.
- R7: The vector register reads the index of the lowest-numbered pending input, or 0xFFFFFFFF when no input is pending.
- R8: The master-enable register holds two bits: bit 0 is the master enable and bit 1 is the hardware-interrupt enable. `irq_out` is a register that is high in the cycle after an edge at which pending was non-zero and both bits were 1, and low otherwise.
- R9: Reset clears status, enable, master enable, the edge history and `irq_out`.
- R10: Status, pending and enable bits at positions N_IN and above read as zero, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_IN | Interrupt request lines |
| reg_addr | input | 5 | Byte address of the register (bits [4:2] used) |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_out | output | 1 | Registered interrupt to the processor |

## Verification
The assertions assume that request lines and register-port inputs are synchronous to `clk` and settled before each edge. They also assume that the kind mask has no bits set above N_IN. The bench drives every input a fixed time after the rising edge. It uses the default kind mask, which marks the upper four of eight inputs as edge-triggered. Random writes go only to the eight decoded addresses and are biased toward keeping both master-enable bits set, so that the output path is exercised often.

// File: rtl/irq_hub_pkg.sv
// Package: shared constants and the register-select type for the interrupt hub.
// Assumes a 32-bit register port with word-aligned byte addresses.
package irq_hub_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int MAX_IN   = 32;
    localparam logic [DATA_W-1:0] NO_IRQ = {DATA_W{1'b1}};

    // Register select, decoded from byte address bits [4:2]
    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_EN     = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VEC    = 3'd6,
        SEL_MASTER = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/irq_hub_capture.sv
// Module: request capture. Keeps one registered copy of each line for
// rising-edge detection and one status bit per input.
// Assumes: lines are synchronous to clk. EDGE_KIND bit i = 1 selects
// rising-edge capture for input i, and 0 selects level capture.
module irq_hub_capture #(
    parameter int          N_IN      = 8,
    parameter logic [31:0] EDGE_KIND = 32'h0000_00F0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] line_in,
    input  logic [N_IN-1:0] ack_mask,
    output logic [N_IN-1:0] status
);

    logic [N_IN-1:0] line_q;
    logic [N_IN-1:0] hit;
    logic [N_IN-1:0] status_q;

    // Per-input trigger kind chosen at elaboration
    for (genvar i = 0; i < N_IN; i++) begin : g_kind
        if (EDGE_KIND[i]) begin : g_edge
            assign hit[i] = line_in[i] & ~line_q[i];
        end else begin : g_level
            assign hit[i] = line_in[i];
        end
    end

    // Line history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_in;
    end

    // Status: a new hit wins over an acknowledge on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~ack_mask) | hit;
    end

    assign status = status_q;

endmodule

// File: rtl/irq_hub_ctrl.sv
// Module: enable and master-enable registers. Handles load, atomic set
// and atomic clear of the enable bits.
// Assumes: at most one register write per cycle, already decoded to a select.
module irq_hub_ctrl #(
    parameter int N_IN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  irq_hub_pkg::reg_sel_e sel,
    input  logic [N_IN-1:0]       wbits,
    input  logic [1:0]            wmaster,
    output logic [N_IN-1:0]       enable,
    output logic [1:0]            master
);
    import irq_hub_pkg::*;

    logic [N_IN-1:0] en_q;
    logic [N_IN-1:0] en_d;
    logic [1:0]      master_q;

    // Next enable value for the three enable-changing writes
    always_comb begin
        en_d = en_q;
        if (wr_en) begin
            case (sel)
                SEL_EN:    en_d = wbits;
                SEL_SETEN: en_d = en_q | wbits;
                SEL_CLREN: en_d = en_q & ~wbits;
                default:   en_d = en_q;
            endcase
        end
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // Master-enable register, two bits
    always_ff @(posedge clk) begin
        if (!rst_n)                          master_q <= 2'b00;
        else if (wr_en && sel == SEL_MASTER) master_q <= wmaster;
    end

    assign enable = en_q;
    assign master = master_q;

endmodule

// File: rtl/irq_hub_prio.sv
// Module: fixed-priority encoder. The lowest pending index wins, and the
// result is all-ones when nothing is pending.
// Assumes N_IN <= 32.
module irq_hub_prio #(
    parameter int N_IN = 8
) (
    input  logic [N_IN-1:0] pend,
    output logic [31:0]     vector
);
    import irq_hub_pkg::*;

    // Scan from the top so the lowest set index is assigned last
    always_comb begin
        vector = NO_IRQ;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (pend[i]) vector = 32'(i);
        end
    end

endmodule

// File: rtl/irq_hub.sv
// Module: interrupt hub top. Decodes the register port, muxes read data
// and registers the processor interrupt.
// Assumes: 1 <= N_IN <= 32, EDGE_KIND zero above N_IN, synchronous inputs.
module irq_hub #(
    parameter int          N_IN      = 8,
    parameter logic [31:0] EDGE_KIND = 32'h0000_00F0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IN-1:0]               irq_in,
    input  logic [irq_hub_pkg::ADDR_W-1:0] reg_addr,
    input  logic                          reg_wr,
    input  logic [irq_hub_pkg::DATA_W-1:0] reg_wdata,
    output logic [irq_hub_pkg::DATA_W-1:0] reg_rdata,
    output logic                          irq_out
);
    import irq_hub_pkg::*;

    reg_sel_e        sel;
    logic [N_IN-1:0] ack_mask;
    logic [N_IN-1:0] status_q;
    logic [N_IN-1:0] enable_q;
    logic [1:0]      master_q;
    logic [N_IN-1:0] pend_w;
    logic [31:0]     vector_w;
    logic            irq_q;
    logic            unused_wdata;

    assign sel          = reg_sel_e'(reg_addr[4:2]);
    assign unused_wdata = ^{reg_wdata, reg_addr[1:0]};

    // Acknowledge mask is live only during a write to the acknowledge register
    assign ack_mask = (reg_wr && sel == SEL_ACK) ? reg_wdata[N_IN-1:0] : '0;

    irq_hub_capture #(.N_IN(N_IN), .EDGE_KIND(EDGE_KIND)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (irq_in),
        .ack_mask (ack_mask),
        .status   (status_q)
    );

    irq_hub_ctrl #(.N_IN(N_IN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .sel     (sel),
        .wbits   (reg_wdata[N_IN-1:0]),
        .wmaster (reg_wdata[1:0]),
        .enable  (enable_q),
        .master  (master_q)
    );

    assign pend_w = status_q & enable_q;

    irq_hub_prio #(.N_IN(N_IN)) u_prio (
        .pend   (pend_w),
        .vector (vector_w)
    );

    // Read-data multiplexer; write-only registers read zero
    always_comb begin
        case (sel)
            SEL_STATUS: reg_rdata = 32'(status_q);
            SEL_PEND:   reg_rdata = 32'(pend_w);
            SEL_EN:     reg_rdata = 32'(enable_q);
            SEL_VEC:    reg_rdata = vector_w;
            SEL_MASTER: reg_rdata = {30'd0, master_q};
            default:    reg_rdata = '0;
        endcase
    end

    // Registered interrupt output gated by both master bits
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (|pend_w) && (master_q == 2'b11);
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/irq_hub_chk.sv
// Module: assertion checker bound into irq_hub. Observes ports and the
// status, enable, master and vector state.
// Assumes synchronous inputs and a valid kind mask.
module irq_hub_chk #(
    parameter int          N_IN      = 8,
    parameter logic [31:0] EDGE_KIND = 32'h0000_00F0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] irq_in,
    input logic [4:0]      reg_addr,
    input logic            reg_wr,
    input logic [31:0]     reg_wdata,
    input logic [N_IN-1:0] status_q,
    input logic [N_IN-1:0] enable_q,
    input logic [1:0]      master_q,
    input logic [31:0]     vector_w,
    input logic            irq_out
);
    localparam logic [N_IN-1:0] LVL = ~EDGE_KIND[N_IN-1:0];

    logic [31:0] pend32;
    logic [31:0] below;
    assign pend32 = 32'(status_q & enable_q);
    assign below  = (32'd1 << vector_w[4:0]) - 32'd1;

    // The kind mask must be clear above the input count (R2, R3)
    initial begin
        if (N_IN < 32) begin
            assert_kind_mask_R2: assert ((EDGE_KIND >> N_IN) == 32'd0);
        end
    end

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & ~$past(status_q) & ~$past(irq_in)) == '0));

    assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(irq_in & LVL)) == $past(irq_in & LVL)));

    assert_set_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr && reg_addr[4:2] == 3'd4))
        |-> ((enable_q & $past(reg_wdata[N_IN-1:0])) == $past(reg_wdata[N_IN-1:0])));

    assert_clr_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr && reg_addr[4:2] == 3'd5))
        |-> ((enable_q & $past(reg_wdata[N_IN-1:0])) == '0));

    assert_vec_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend32 == 32'd0) |-> (vector_w == 32'hFFFF_FFFF));

    assert_vec_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend32 != 32'd0) |-> (pend32[vector_w[4:0]] && ((pend32 & below) == 32'd0)));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_out) |-> ($past(master_q) == 2'b11));

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(master_q) == 2'b11 && $past(|(status_q & enable_q)))
        |-> irq_out);

endmodule

bind irq_hub irq_hub_chk #(.N_IN(N_IN), .EDGE_KIND(EDGE_KIND)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .master_q  (master_q),
    .vector_w  (vector_w),
    .irq_out   (irq_out)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/100ps
module sim_irq_hub;
    localparam int          N    = 8;
    localparam logic [31:0] KIND = 32'h0000_00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_hub #(.N_IN(N), .EDGE_KIND(KIND)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // Reference state, updated from the requirements at each edge
    logic [N-1:0] m_stat, m_en, m_lq;
    logic [1:0]   m_mer;
    logic         m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat <= '0; m_en <= '0; m_lq <= '0; m_mer <= 2'b00; m_irq <= 1'b0;
        end else begin
            logic [N-1:0] hit, ack;
            hit = (irq_in & ~KIND[N-1:0]) | (irq_in & KIND[N-1:0] & ~m_lq);
            ack = (reg_wr && reg_addr[4:2] == 3'd3) ? reg_wdata[N-1:0] : '0;
            m_stat <= (m_stat & ~ack) | hit;
            m_lq   <= irq_in;
            m_irq  <= (|(m_stat & m_en)) && (m_mer == 2'b11);
            if (reg_wr) begin
                case (reg_addr[4:2])
                    3'd2: m_en  <= reg_wdata[N-1:0];
                    3'd4: m_en  <= m_en | reg_wdata[N-1:0];
                    3'd5: m_en  <= m_en & ~reg_wdata[N-1:0];
                    3'd7: m_mer <= reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_vec(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_read(input int s);
        case (s)
            0: return 32'(m_stat);
            1: return 32'(m_stat & m_en);
            2: return 32'(m_en);
            6: return exp_vec(m_stat & m_en);
            7: return {30'd0, m_mer};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic wr(input int s, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 5'(s << 2); reg_wdata = d;
        tick();
    endtask

    task automatic rd(input int s, output logic [31:0] v);
        reg_addr = 5'(s << 2); #0.5; v = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input int s, input logic [31:0] exp);
        logic [31:0] v;
        rd(s, v);
        check(req, v, exp);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9: reset state
        chk_reg("R9 status", 0, 32'd0);
        chk_reg("R9 enable", 2, 32'd0);
        chk_reg("R9 master", 7, 32'd0);
        chk_reg("R7 vector empty", 6, 32'hFFFF_FFFF);
        check("R9 irq_out", 32'(irq_out), 32'd0);

        wr(2, 32'hFF);
        wr(7, 32'h3);
        // R2: edge input 5 captured once
        irq_in[5] = 1'b1; tick();
        chk_reg("R2 edge set", 0, 32'h20);
        wr(3, 32'h20);
        chk_reg("R2 held high no reset", 0, 32'h0);
        // R3: level input 2 resists acknowledge while high
        irq_in[2] = 1'b1; tick();
        chk_reg("R3 level set", 0, 32'h04);
        wr(3, 32'h04);
        chk_reg("R3 ack while high", 0, 32'h04);
        irq_in[2] = 1'b0; tick();
        check("R8 irq asserted", 32'(irq_out), 32'd1);
        wr(3, 32'h04);
        chk_reg("R3 ack after drop", 0, 32'h0);

        // R7 priority with R5 atomic enable changes
        irq_in = 8'h48; tick();
        chk_reg("R7 lowest wins", 6, 32'd3);
        wr(5, 32'h08);
        chk_reg("R5 clear-enable", 2, 32'hF7);
        chk_reg("R6 pending", 1, 32'h40);
        chk_reg("R7 next lowest", 6, 32'd6);
        wr(4, 32'h08);
        chk_reg("R5 set-enable", 2, 32'hFF);
        chk_reg("R7 restored", 6, 32'd3);

        // R8: both master bits needed
        wr(7, 32'h1); tick();
        check("R8 master bit1 clear", 32'(irq_out), 32'd0);
        wr(7, 32'h2); tick();
        check("R8 master bit0 clear", 32'(irq_out), 32'd0);
        wr(7, 32'h3); tick();
        check("R8 both bits", 32'(irq_out), 32'd1);

        // R4: acknowledge all
        irq_in = '0; tick();
        wr(3, 32'hFFFF_FFFF);
        chk_reg("R4 ack all", 0, 32'd0);
        chk_reg("R4 vector after ack", 6, 32'hFFFF_FFFF);
        tick();
        check("R8 irq drops", 32'(irq_out), 32'd0);

        // R10 / R1 / R5
        wr(2, 32'hFFFF_FFFF);
        chk_reg("R10 upper enable bits", 2, 32'hFF);
        wr(0, 32'hFF);
        chk_reg("R1 status write ignored", 0, 32'd0);
        wr(6, 32'h5);
        chk_reg("R1 vector write ignored", 6, 32'hFFFF_FFFF);
        chk_reg("R1 ack reads zero", 3, 32'd0);
        wr(2, 32'd0);
        chk_reg("R5 enable zero", 2, 32'd0);

        // Random phase compared against the reference state
        for (int c = 0; c < 3000; c++) begin
            irq_in = N'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                int s;
                logic [31:0] d;
                s = int'($urandom_range(0, 7));
                d = $urandom;
                if (s == 7 && $urandom_range(0, 3) != 0) d = 32'h3;
                reg_wr = 1'b1; reg_addr = 5'(s << 2); reg_wdata = d;
            end
            tick();
            for (int s = 0; s < 8; s++) begin
                rd(s, v);
                check("R1 R2 R3 R4 R5 R6 R7 random", v, exp_read(s));
            end
            check("R8 random irq", 32'(irq_out), 32'(m_irq));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule